// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire I2C bus that has been left stuck, for example after the host controller has seen arbitration or acknowledge errors, or has found the bus busy with no transfer running. It controls SCL and SDA only through open-drain pull-down enables, so it never drives a line high. It reads both lines back through a two-stage synchronizer.

A start request makes the block check the bus. While SDA reads low, it clocks SCL one pulse at a time and checks the lines after each pulse. Pulsing stops as soon as both lines read high, and it never goes past nine pulses. On a free bus the block always generates a STOP condition, so every conforming target resets its own state machine. A target that stretches the clock only delays the sequence. If SCL stays low past a long stretch timeout, the block gives up and reports a fault that only a target reset can clear. The status outputs, with the number of pulses used, are held until the next start.

Top module: `i2c_bus_rescue`

## Requirements
- R1: After reset both line enables are released (1), and busy_o, done_o, every status output and pulses_o are 0.
- R2: start_i is accepted only while idle. busy_o is 1 from the cycle after the accepting edge until the run ends, and start_i has no effect while busy_o is 1.
- R3: Every decision uses the line levels after two synchronizing flip-flops, so a level change at the pins takes effect two clock edges later.
- R4: A recovery pulse holds scl_oe_no at 0 for exactly HALF_CYC cycles. Each high phase ends only after HALF_CYC consecutive cycles in which the synchronized SCL reads high.
- R5: At the end of each high phase, a high synchronized SDA ends pulsing and starts the STOP sequence. pulses_o counts the pulses issued and is incremented when each pulse begins.
- R6: At most MAX_PULSES (9) pulses are issued. If SDA is still low at the end of the high phase after the last pulse, both lines are released, done_o pulses, sda_fail_o goes to 1 and pulses_o reads 9.
- R7: The STOP sequence has four phases: SCL low with SDA released for HALF_CYC cycles; SCL and SDA low for HALF_CYC cycles; SCL released with SDA low until SCL has read high for HALF_CYC cycles; both released for HALF_CYC cycles. Then done_o pulses and ok_o goes to 1. SDA is released only while SCL is released.
- R8: If both lines read high when start is accepted, only the STOP sequence runs, and the run ends with ok_o at 1 and pulses_o at 0.
- R9: In any phase where SCL is released, STRETCH_CYC consecutive cycles of low synchronized SCL end the run. Both lines are released, done_o pulses and scl_fail_o goes to 1.
- R10: A shorter SCL low period caused by target clock stretching only delays the high phase. It does not cause a fault.
- R11: done_o lasts exactly one cycle. At most one of ok_o, sda_fail_o and scl_fail_o is 1. All of them hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a recovery run |
| scl_i | input | 1 | SCL line level as read at the pin |
| sda_i | input | 1 | SDA line level as read at the pin |
| scl_oe_no | output | 1 | SCL pull-down enable, 0 pulls the line low |
| sda_oe_no | output | 1 | SDA pull-down enable, 0 pulls the line low |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| ok_o | output | 1 | Bus freed and STOP sent |
| sda_fail_o | output | 1 | SDA still low after the last pulse |
| scl_fail_o | output | 1 | SCL held low past the stretch timeout |
| pulses_o | output | PCNT_W (4) | Pulses used by the last or current run |

## Verification
The assertions assume that the line inputs behave like a real open-drain bus. A line can read high only while this block releases it, and the only thing that may hold a line low is a target: holding SDA for a number of clock falls, stretching SCL after a fall, or keeping SCL stuck. The bench builds the pins as the wired-AND of the block's enables and a behavioural target. It changes the target's settings only between runs, so the bus never reads high while the block pulls a line low. start_i is driven away from the clock edge, including once while a run is in progress.

// File: rtl/i2c_rescue_pkg.sv
package i2c_rescue_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_HIGH,    // SCL released, wait for high phase
    RS_LOW,     // recovery pulse low phase
    RS_STOP_A,  // SCL low, SDA released
    RS_STOP_B,  // SCL low, SDA low
    RS_STOP_C,  // SCL released, SDA low
    RS_STOP_D   // both released
  } rs_state_e;

  typedef enum logic [1:0] {
    END_OK,
    END_SDA,
    END_SCL
  } rs_end_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '1;  // idle bus reads high
      else         stg_q[s] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
  import i2c_rescue_pkg::*;
#(
  parameter int HALF_CYC    = 1000,
  parameter int STRETCH_CYC = 1_000_000,
  parameter int MAX_PULSES  = 9,
  localparam int PCNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_no,
  output logic              sda_oe_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              sda_fail_o,
  output logic              scl_fail_o,
  output logic [PCNT_W-1:0] pulses_o
);
  localparam int HALF_W = $clog2(HALF_CYC + 1);
  localparam int STR_W  = $clog2(STRETCH_CYC + 1);

  rs_state_e        state_q, state_d;
  logic [1:0]       lines_s;
  logic             scl_s, sda_s;
  logic [HALF_W-1:0] hcnt;
  logic [STR_W-1:0]  scnt;
  logic             in_wait, half_done, str_done, moving;
  logic             h_clr, s_clr;
  logic             finish;
  rs_end_e          end_code;

  line_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );
  assign {scl_s, sda_s} = lines_s;

  assign in_wait   = (state_q == RS_HIGH) || (state_q == RS_STOP_C);
  assign half_done = (hcnt == HALF_W'(HALF_CYC - 1));
  assign str_done  = (scnt == STR_W'(STRETCH_CYC - 1));
  assign moving    = (state_d != state_q);

  assign h_clr = moving || (state_q == RS_IDLE) || (in_wait && !scl_s);
  assign s_clr = moving || !(in_wait && !scl_s);

  cyc_counter #(.WIDTH(HALF_W)) u_half (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (h_clr), .inc_i (!h_clr), .cnt_o (hcnt)
  );

  cyc_counter #(.WIDTH(STR_W)) u_stretch (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (s_clr), .inc_i (!s_clr), .cnt_o (scnt)
  );

  always_comb begin
    state_d  = state_q;
    finish   = 1'b0;
    end_code = END_OK;
    unique case (state_q)
      RS_IDLE: if (start_i) state_d = RS_HIGH;
      RS_HIGH: begin
        if (!scl_s && str_done) begin
          finish = 1'b1; end_code = END_SCL; state_d = RS_IDLE;
        end else if (scl_s && half_done) begin
          if (sda_s) state_d = RS_STOP_A;
          else if (pulses_o == PCNT_W'(MAX_PULSES)) begin
            finish = 1'b1; end_code = END_SDA; state_d = RS_IDLE;
          end else state_d = RS_LOW;
        end
      end
      RS_LOW:    if (half_done) state_d = RS_HIGH;
      RS_STOP_A: if (half_done) state_d = RS_STOP_B;
      RS_STOP_B: if (half_done) state_d = RS_STOP_C;
      RS_STOP_C: begin
        if (!scl_s && str_done) begin
          finish = 1'b1; end_code = END_SCL; state_d = RS_IDLE;
        end else if (scl_s && half_done) state_d = RS_STOP_D;
      end
      RS_STOP_D: if (half_done) begin
        finish = 1'b1; state_d = RS_IDLE;
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RS_IDLE;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      sda_fail_o <= 1'b0;
      scl_fail_o <= 1'b0;
      pulses_o   <= '0;
    end else begin
      state_q <= state_d;
      done_o  <= finish;
      if (state_q == RS_IDLE && start_i) begin
        ok_o <= 1'b0; sda_fail_o <= 1'b0; scl_fail_o <= 1'b0;
        pulses_o <= '0;
      end
      if (state_q == RS_HIGH && state_d == RS_LOW) pulses_o <= pulses_o + 1'b1;
      if (finish) begin
        ok_o       <= (end_code == END_OK);
        sda_fail_o <= (end_code == END_SDA);
        scl_fail_o <= (end_code == END_SCL);
      end
    end
  end

  assign busy_o    = (state_q != RS_IDLE);
  assign scl_oe_no = !(state_q inside {RS_LOW, RS_STOP_A, RS_STOP_B});
  assign sda_oe_no = !(state_q inside {RS_STOP_B, RS_STOP_C});

  a_r6_pulse_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_o <= PCNT_W'(MAX_PULSES));

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_one_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, sda_fail_o, scl_fail_o}));

  a_r7_sda_rise_scl_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_no) |-> scl_oe_no);

  a_r2_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !finish) |=> busy_o);

  a_r9_fault_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_fail_o) |-> done_o);

  a_r4_low_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_oe_no |-> busy_o);
endmodule

// File: tb/i2c_bus_rescue_tb.sv
`timescale 1ns/1ps
module i2c_bus_rescue_tb;
  localparam int HALF = 4;
  localparam int STR  = 40;
  localparam int MAXP = 9;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_oe_no, sda_oe_no, busy, done, ok, sda_fail, scl_fail;
  logic [3:0] pulses;
  wire scl_bus, sda_bus;

  // behavioural target
  int cfg_release_at = 0, cfg_base = 0, cfg_stretch = 0;
  bit cfg_scl_stuck = 0;
  int fall_cnt = 0, stretch_cnt = 0;
  bit prev_scl = 1;
  wire tgt_sda_low = (fall_cnt - cfg_base) < cfg_release_at;
  wire tgt_scl_low = (stretch_cnt != 0) || cfg_scl_stuck;
  assign scl_bus = scl_oe_no & ~tgt_scl_low;
  assign sda_bus = sda_oe_no & ~tgt_sda_low;

  always @(posedge clk) begin
    prev_scl <= scl_bus;
    if (prev_scl && !scl_bus) begin
      fall_cnt    <= fall_cnt + 1;
      stretch_cnt <= cfg_stretch;
    end else if (stretch_cnt != 0) stretch_cnt <= stretch_cnt - 1;
  end

  i2c_bus_rescue #(.HALF_CYC(HALF), .STRETCH_CYC(STR), .MAX_PULSES(MAXP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_no(scl_oe_no), .sda_oe_no(sda_oe_no), .busy_o(busy), .done_o(done),
    .ok_o(ok), .sda_fail_o(sda_fail), .scl_fail_o(scl_fail), .pulses_o(pulses)
  );

  int errs = 0, checks = 0;
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle,1 high wait,2 low,3..6 stop steps
  int m_ph = 0, m_age = 0, m_low = 0, m_pulses = 0;
  bit m_done = 0, m_ok = 0, m_sf = 0, m_cf = 0;
  bit m_scl_m = 1, m_scl_s = 1, m_sda_m = 1, m_sda_s = 1;

  task automatic m_end(input int code);
    m_ph = 0; m_done = 1;
    m_ok = (code == 0); m_sf = (code == 1); m_cf = (code == 2);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_age = 0; m_low = 0; m_pulses = 0;
      m_done = 0; m_ok = 0; m_sf = 0; m_cf = 0;
      m_scl_m = 1; m_scl_s = 1; m_sda_m = 1; m_sda_s = 1;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (start) begin
          m_ph = 1; m_age = 0; m_low = 0; m_pulses = 0;
          m_ok = 0; m_sf = 0; m_cf = 0;
        end
      end else if (m_ph == 1 || m_ph == 5) begin
        if (!m_scl_s) begin
          m_age = 0; m_low++;
          if (m_low == STR) m_end(2);
        end else begin
          m_low = 0; m_age++;
          if (m_age == HALF) begin
            m_age = 0;
            if (m_ph == 5) m_ph = 6;
            else if (m_sda_s) m_ph = 3;
            else if (m_pulses == MAXP) m_end(1);
            else begin m_ph = 2; m_pulses++; end
          end
        end
      end else begin
        m_age++;
        if (m_age == HALF) begin
          m_age = 0; m_low = 0;
          case (m_ph)
            2: m_ph = 1;
            3: m_ph = 4;
            4: m_ph = 5;
            default: m_end(0);
          endcase
        end
      end
      m_scl_s = m_scl_m; m_scl_m = scl_bus;
      m_sda_s = m_sda_m; m_sda_m = sda_bus;
    end
  end

  bit cmp_en = 0;
  always @(negedge clk) if (rst_n && cmp_en) begin
    chk("R2 busy", busy, m_ph != 0);
    chk("R4 scl_oe_no", scl_oe_no, !(m_ph inside {2, 3, 4}));
    chk("R7 sda_oe_no", sda_oe_no, !(m_ph inside {4, 5}));
    chk("R11 done", done, m_done);
    chk("R7 ok", ok, m_ok);
    chk("R6 sda_fail", sda_fail, m_sf);
    chk("R9 scl_fail", scl_fail, m_cf);
    chk("R5 pulses", pulses, m_pulses);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run_case(input string tag, input int rel, input int strc, input bit stuck,
                          input bit mid, input int e_ok, input int e_sf, input int e_cf,
                          input int e_p);
    int n = 0;
    @(negedge clk);
    cfg_release_at = rel; cfg_stretch = strc; cfg_scl_stuck = stuck; cfg_base = fall_cnt;
    start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " busy after start"}, busy, 1);
    if (mid) begin
      repeat (6) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk({tag, " done"}, done, 1);
    chk({tag, " ok"}, ok, e_ok);
    chk({tag, " sda_fail"}, sda_fail, e_sf);
    chk({tag, " scl_fail"}, scl_fail, e_cf);
    chk({tag, " pulses"}, pulses, e_p);
    chk({tag, " lines released"}, {scl_oe_no, sda_oe_no}, 2'b11);
    @(negedge clk);
    cfg_release_at = 0; cfg_stretch = 0; cfg_scl_stuck = 0;
    chk({tag, " R11 done one cycle"}, done, 0);
    chk({tag, " R11 status held"}, {ok, sda_fail, scl_fail}, {e_ok[0], e_sf[0], e_cf[0]});
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset enables", {scl_oe_no, sda_oe_no}, 2'b11);
    chk("R1 reset busy/done", {busy, done}, 2'b00);
    chk("R1 reset status", {ok, sda_fail, scl_fail}, 3'b000);
    chk("R1 reset pulses", pulses, 0);
    cmp_en = 1;
    run_case("R8 free bus", 0, 0, 0, 0, 1, 0, 0, 0);
    run_case("R5 release after 3 (R3)", 3, 0, 0, 0, 1, 0, 0, 3);
    run_case("R2 start ignored while busy", 3, 0, 0, 1, 1, 0, 0, 3);
    run_case("R6 release on last pulse", 9, 0, 0, 0, 1, 0, 0, 9);
    run_case("R6 sda never released", 100, 0, 0, 0, 0, 1, 0, 9);
    run_case("R10 stretched clock", 2, 10, 0, 0, 1, 0, 0, 2);
    run_case("R10 stretch near limit", 1, STR - 4, 0, 0, 1, 0, 0, 1);
    run_case("R9 scl stuck", 0, 0, 1, 0, 0, 0, 1, 0);
    run_case("R8 free bus again", 0, 0, 0, 0, 1, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule